// File: doc/BRIEF.md
# Serial Configuration PROM Word Engine

This block lets a host read or write one 16-bit word of a small serial configuration PROM. The PROM holds 64 words and is reached over a three-wire serial link: a select, a clock and a data line in each direction. The host sees three registers. The pointer holds the word address. The general word holds write data, and it receives the data of a read. The control register starts a command.

The host writes the pointer, and for a store also the general word. It then writes the control register with the PROM-select bit and either the reload bit or the store bit. The engine sends the serial instruction. Before the first store after reset, it also sends a single write-enable instruction. After a store, it waits for the PROM to signal the end of programming. When the command is done, the engine clears the command bit. The host polls that bit to learn whether the engine is busy. During a command, the engine ignores every host write.

Top module: `prom_word_engine`

## Requirements
- R1: After reset all three host registers read zero, and the serial select, clock and data-out lines are low.
- R2: A pointer write keeps only the low 6 bits of the written word as the address.
- R3: Writing the control register with bit 2 (select) and bit 1 (reload) both set starts a read. The frame is a start bit 1, opcode 10 and the 6 address bits, MSB first. The engine then captures the next 16 bits from the PROM, MSB first, into the general word.
- R4: Writing the control register with bit 2 and bit 0 (store) both set starts a write. The frame is a start bit 1, opcode 01, the 6 address bits and then the 16 bits of the general word, all MSB first.
- R5: Bits 0 and 1 of the control register stay set while their command runs and clear themselves when it finishes. At most one of them is set at a time. Bit 2 keeps the value the host wrote.
- R6: The engine sends the write-enable instruction before the first write after reset, and only then. That instruction is start bit 1, opcode 00 and address 110000.
- R7: After a write frame, the engine drops the select line for a gap. It then raises select and waits until the PROM drives its data line high. Only after that does the store bit clear.
- R8: Select stays low for at least one serial clock period (2*CLK_DIV system clocks) between two instructions. The serial clock pulses only while select is high.
- R9: While bit 0 or bit 1 is set, host writes to the pointer, the general word and the control register have no effect.
- R10: A control write that sets reload or store without the select bit starts nothing and leaves bits 0 and 1 clear.
- R11: The data line toward the PROM does not change while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 general word, 2 control |
| reg_wdata | input | 16 | Host write data |
| ctl_rd | output | 3 | Control register: bit 0 store, bit 1 reload, bit 2 select |
| ptr_rd | output | 6 | Pointer register (word address) |
| gp_rd | output | 16 | General word register |
| ee_cs | output | 1 | Serial select to the PROM, active high |
| ee_sk | output | 1 | Serial clock to the PROM |
| ee_di | output | 1 | Serial data to the PROM |
| ee_do | input | 1 | Serial data from the PROM; high also means ready after programming |

## Verification
The testbench includes a behavioural PROM that decodes frames bit by bit on rising serial clock edges.

The engine first reads all 64 words from a memory filled with one arithmetic pattern, then stores a second pattern to every word, then reads every word back. The first sweep checks the read frame and the MSB-first capture independently of the write path. The store sweep and the direct inspection of the model memory check the write frame, the data order and that write-enable is sent once. Comparing the model memory with the readback tells an addressing fault apart from a data-order fault.

Separate patterns cover the rest. One writes a pointer with high bits set. One sends commands that lack the select bit. One writes to every register while a store is running. These show masking and the rules for ignored writes, which the sweeps alone cannot show.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic [1:0] {
        REG_PTR  = 2'd0,
        REG_GP   = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } host_reg_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WEN,
        ST_WEN_GAP,
        ST_XFER,
        ST_MID_GAP,
        ST_POLL,
        ST_END_GAP
    } seq_e;

    localparam int CTL_STORE  = 0;
    localparam int CTL_RELOAD = 1;
    localparam int CTL_SEL    = 2;

    localparam logic [1:0] OP_RD  = 2'b10;
    localparam logic [1:0] OP_WR  = 2'b01;
    localparam logic [1:0] OP_EXT = 2'b00;

endpackage

// File: rtl/prom_sk_tick.sv
module prom_sk_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CW'(DIV - 1));
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/prom_frame_shifter.sv
module prom_frame_shifter #(
    parameter int FW = 25,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          start_i,
    input  logic [FW-1:0] frame_i,
    input  logic [LW-1:0] len_i,
    input  logic          sdo_i,
    output logic          sk_o,
    output logic          sdi_o,
    output logic          done_o,
    output logic [FW-1:0] shreg_o
);
    typedef struct packed {
        logic          act;
        logic          hi;
        logic          done;
        logic [LW-1:0] left;
        logic [FW-1:0] sh;
    } sh_st_t;

    sh_st_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i && !q.act) begin
            d.act  = 1'b1;
            d.hi   = 1'b0;
            d.left = len_i;
            d.sh   = frame_i;
        end else if (q.act && tick_i) begin
            if (!q.hi) begin
                d.hi = 1'b1;
            end else begin
                d.hi   = 1'b0;
                d.sh   = {q.sh[FW-2:0], sdo_i};
                d.left = q.left - 1'b1;
                if (q.left == LW'(1)) begin
                    d.act  = 1'b0;
                    d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sk_o    = q.act & q.hi;
    assign sdi_o   = q.act & q.sh[FW-1];
    assign done_o  = q.done;
    assign shreg_o = q.sh;
endmodule

// File: rtl/prom_word_engine.sv
module prom_word_engine
    import prom_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int DW      = 16,
    parameter int CLK_DIV = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int FW = 3 + AW + DW,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [2:0]    ctl_rd,
    output logic [AW-1:0] ptr_rd,
    output logic [DW-1:0] gp_rd,
    output logic          ee_cs,
    output logic          ee_sk,
    output logic          ee_di,
    input  logic          ee_do
);
    typedef struct packed {
        seq_e          st;
        logic [1:0]    gap;
        logic          wen_done;
        logic          rd_op;
        logic [2:0]    ctl;
        logic [AW-1:0] ptr;
        logic [DW-1:0] gp;
    } eng_st_t;

    eng_st_t d, q;

    logic          tick;
    logic          sh_start;
    logic [FW-1:0] sh_frame;
    logic [LW-1:0] sh_len;
    logic          sh_done;
    logic [FW-1:0] sh_reg;
    logic          busy;
    logic          gap_over;

    prom_sk_tick #(.DIV(CLK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    prom_frame_shifter #(.FW(FW)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .start_i (sh_start),
        .frame_i (sh_frame),
        .len_i   (sh_len),
        .sdo_i   (ee_do),
        .sk_o    (ee_sk),
        .sdi_o   (ee_di),
        .done_o  (sh_done),
        .shreg_o (sh_reg)
    );

    always_comb begin
        d        = q;
        sh_start = 1'b0;
        sh_frame = '0;
        sh_len   = LW'(FW);
        busy     = |q.ctl[1:0];
        gap_over = tick && (q.gap == 2'd2);
        if (tick && q.gap != 2'd3) d.gap = q.gap + 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (reg_we && !busy) begin
                    case (host_reg_e'(reg_sel))
                        REG_PTR: d.ptr = reg_wdata[AW-1:0];
                        REG_GP:  d.gp  = reg_wdata;
                        REG_CTL: begin
                            d.ctl[CTL_SEL] = reg_wdata[CTL_SEL];
                            if (reg_wdata[CTL_SEL] && reg_wdata[CTL_RELOAD]) begin
                                d.ctl[CTL_RELOAD] = 1'b1;
                                d.rd_op           = 1'b1;
                                d.st              = ST_XFER;
                                sh_start          = 1'b1;
                                sh_frame          = {1'b1, OP_RD, q.ptr, {DW{1'b0}}};
                            end else if (reg_wdata[CTL_SEL] && reg_wdata[CTL_STORE]) begin
                                d.ctl[CTL_STORE] = 1'b1;
                                d.rd_op          = 1'b0;
                                sh_start         = 1'b1;
                                if (q.wen_done) begin
                                    d.st     = ST_XFER;
                                    sh_frame = {1'b1, OP_WR, q.ptr, q.gp};
                                end else begin
                                    d.st     = ST_WEN;
                                    sh_len   = LW'(3 + AW);
                                    sh_frame = {1'b1, OP_EXT, 2'b11, {(AW-2){1'b0}}, {DW{1'b0}}};
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_WEN: begin
                if (sh_done) begin
                    d.st       = ST_WEN_GAP;
                    d.gap      = '0;
                    d.wen_done = 1'b1;
                end
            end
            ST_WEN_GAP: begin
                if (gap_over) begin
                    d.st     = ST_XFER;
                    sh_start = 1'b1;
                    sh_frame = {1'b1, OP_WR, q.ptr, q.gp};
                end
            end
            ST_XFER: begin
                if (sh_done) begin
                    d.gap = '0;
                    if (q.rd_op) begin
                        d.gp = sh_reg[DW-1:0];
                        d.st = ST_END_GAP;
                    end else begin
                        d.st = ST_MID_GAP;
                    end
                end
            end
            ST_MID_GAP: begin
                if (gap_over) d.st = ST_POLL;
            end
            ST_POLL: begin
                if (tick && ee_do) begin
                    d.st  = ST_END_GAP;
                    d.gap = '0;
                end
            end
            ST_END_GAP: begin
                if (gap_over) begin
                    d.st                            = ST_IDLE;
                    d.ctl[CTL_RELOAD:CTL_STORE]     = 2'b00;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign ee_cs  = (q.st == ST_WEN) || (q.st == ST_XFER) || (q.st == ST_POLL);
    assign ctl_rd = q.ctl;
    assign ptr_rd = q.ptr;
    assign gp_rd  = q.gp;
endmodule

// File: rtl/prom_word_engine_chk.sv
module prom_word_engine_chk #(
    parameter int AW      = 6,
    parameter int DW      = 16,
    parameter int CLK_DIV = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    ctl_rd,
    input logic [AW-1:0] ptr_rd,
    input logic [DW-1:0] gp_rd,
    input logic          ee_cs,
    input logic          ee_sk,
    input logic          ee_di
);
    logic [15:0] low_cnt_q;
    logic        seen_fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q   <= '0;
            seen_fall_q <= 1'b0;
        end else begin
            if (ee_cs)                    low_cnt_q <= '0;
            else if (low_cnt_q != 16'hFFFF) low_cnt_q <= low_cnt_q + 1'b1;
            if (!ee_cs && low_cnt_q == '0) seen_fall_q <= seen_fall_q | 1'b1;
        end
    end

    assert_cmd_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_rd[1:0]));

    assert_sk_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_fall_q && $rose(ee_cs)) |-> (low_cnt_q >= 16'(2 * CLK_DIV)));

    assert_di_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    assert_ptr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctl_rd[1:0]) |=> $stable(ptr_rd));

    assert_gp_frozen_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd[0] |=> $stable(gp_rd));

    assert_cmd_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_rd[1]) || $rose(ctl_rd[0])) |-> ctl_rd[2]);
endmodule

bind prom_word_engine prom_word_engine_chk #(
    .AW(AW), .DW(DW), .CLK_DIV(CLK_DIV)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_rd (ctl_rd),
    .ptr_rd (ptr_rd),
    .gp_rd  (gp_rd),
    .ee_cs  (ee_cs),
    .ee_sk  (ee_sk),
    .ee_di  (ee_di)
);

// File: tb/prom_word_engine_tb.sv
module prom_word_engine_tb_top;
    localparam int DIV  = 3;
    localparam int PROG = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  ctl_rd;
    logic [5:0]  ptr_rd;
    logic [15:0] gp_rd;
    logic        ee_cs, ee_sk, ee_di, ee_do;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    prom_word_engine #(.DEPTH(64), .DW(16), .CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl_rd(ctl_rd), .ptr_rd(ptr_rd), .gp_rd(gp_rd),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    function automatic logic [15:0] pat_a(int i);
        return 16'((i * 16'h1357) ^ 16'h8C21);
    endfunction
    function automatic logic [15:0] pat_b(int i);
        return 16'((i * 16'h2F1B) ^ 16'h5AA5);
    endfunction

    // behavioural serial PROM
    logic [15:0] mem [64];
    logic        sk_p, cs_p, di_p;
    int          bitn;
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [15:0] wdat;
    logic        rd_mode, rd_bit, ewen, wr_pend, wen_before_wr;
    logic [5:0]  pend_addr;
    logic [15:0] pend_data;
    int          prog_cnt, wen_frames, cs_rises, low_run, min_gap, di_glitch;
    bit          seen_fall;

    assign ee_do = rd_mode ? rd_bit : (prog_cnt == 0 && !wr_pend);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= pat_a(i);
            sk_p <= 0; cs_p <= 0; di_p <= 0; bitn <= 0; op <= 0; addr <= 0; wdat <= 0;
            rd_mode <= 0; rd_bit <= 0; ewen <= 0; wr_pend <= 0; wen_before_wr <= 1;
            pend_addr <= 0; pend_data <= 0; prog_cnt <= 0; wen_frames <= 0;
            cs_rises <= 0; low_run <= 0; min_gap <= 1000000; di_glitch <= 0; seen_fall <= 0;
        end else begin
            sk_p <= ee_sk; cs_p <= ee_cs; di_p <= ee_di;
            if (prog_cnt > 0) prog_cnt <= prog_cnt - 1;
            if (ee_sk && sk_p && ee_di != di_p) di_glitch <= di_glitch + 1;
            if (!ee_cs) low_run <= low_run + 1;
            else low_run <= 0;
            if (ee_cs && !cs_p) begin
                cs_rises <= cs_rises + 1;
                if (seen_fall && low_run < min_gap) min_gap <= low_run;
            end
            if (!ee_cs) begin
                bitn <= 0; rd_mode <= 0;
                if (cs_p) seen_fall <= 1;
                if (cs_p && wr_pend) begin
                    if (ewen) mem[pend_addr] <= pend_data;
                    prog_cnt <= PROG;
                    wr_pend  <= 0;
                end
            end else if (ee_sk && !sk_p) begin
                if (bitn == 0) begin
                    if (ee_di) bitn <= 1;
                end else begin
                    bitn <= bitn + 1;
                    if (bitn <= 2) op <= {op[0], ee_di};
                    else if (bitn <= 8) addr <= {addr[4:0], ee_di};
                    if (bitn == 8) begin
                        if (op == 2'b10) rd_mode <= 1;
                        if (op == 2'b00 && addr[4:3] == 2'b11) begin
                            ewen <= 1; wen_frames <= wen_frames + 1;
                        end
                        if (op == 2'b01 && !ewen) wen_before_wr <= 0;
                    end
                    if (bitn >= 9 && bitn <= 24) begin
                        if (rd_mode) rd_bit <= mem[addr][24 - bitn];
                        if (op == 2'b01) wdat <= {wdat[14:0], ee_di};
                        if (op == 2'b01 && bitn == 24) begin
                            wr_pend <= 1; pend_addr <= addr; pend_data <= {wdat[14:0], ee_di};
                        end
                    end
                end
            end
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(logic [1:0] sel, logic [15:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (ctl_rd[1:0] != 2'b00) @(negedge clk);
    endtask

    task automatic do_read(int a);
        host_wr(2'd0, 16'(a));
        host_wr(2'd2, 16'h0006);
        wait_idle();
    endtask

    initial begin
        int rises0;
        repeat (3) @(negedge clk);
        check(ctl_rd == 0 && ptr_rd == 0 && gp_rd == 0, "R1 regs", {ctl_rd, ptr_rd, gp_rd}, 0);
        check(!ee_cs && !ee_sk && !ee_di, "R1 lines", {ee_cs, ee_sk, ee_di}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ctl_rd == 0 && ptr_rd == 0 && gp_rd == 0, "R1 after release", {ctl_rd, ptr_rd, gp_rd}, 0);

        host_wr(2'd0, 16'hFFC5);
        check(ptr_rd == 6'd5, "R2 mask", ptr_rd, 5);
        host_wr(2'd0, 16'h7A3F);
        check(ptr_rd == 6'h3F, "R2 mask high", ptr_rd, 6'h3F);

        // R10: command without select
        rises0 = cs_rises;
        host_wr(2'd2, 16'h0002);
        repeat (60) @(negedge clk);
        check(ctl_rd == 3'b000 && cs_rises == rises0, "R10 reload no sel", {ctl_rd, 8'(cs_rises - rises0)}, 0);
        host_wr(2'd2, 16'h0001);
        repeat (60) @(negedge clk);
        check(ctl_rd == 3'b000 && cs_rises == rises0, "R10 store no sel", {ctl_rd, 8'(cs_rises - rises0)}, 0);

        // R3: read sweep of initial contents
        for (int a = 0; a < 64; a++) begin
            do_read(a);
            check(gp_rd == pat_a(a), "R3 read initial", gp_rd, pat_a(a));
        end
        check(ctl_rd == 3'b100, "R5 sel kept", ctl_rd, 3'b100);

        // R4/R5/R7: write sweep
        for (int a = 0; a < 64; a++) begin
            host_wr(2'd0, 16'(a));
            host_wr(2'd1, pat_b(a));
            host_wr(2'd2, 16'h0005);
            if (a == 0) begin
                check(ctl_rd == 3'b101, "R5 store busy", ctl_rd, 3'b101);
                while (prog_cnt == 0) @(negedge clk);
                check(ctl_rd[0] == 1'b1, "R7 busy during programming", ctl_rd, 3'b101);
            end
            wait_idle();
            if (a == 0) check(prog_cnt == 0 && ctl_rd == 3'b100, "R7 done after ready", {ctl_rd, 16'(prog_cnt)}, 3'b100);
        end
        for (int a = 0; a < 64; a++)
            check(mem[a] == pat_b(a), "R4 stored word", mem[a], pat_b(a));
        check(wen_frames == 1 && wen_before_wr, "R6 write enable once", wen_frames, 1);

        for (int a = 0; a < 64; a++) begin
            do_read(a);
            check(gp_rd == pat_b(a), "R3 read back", gp_rd, pat_b(a));
        end

        // R9: writes while busy
        host_wr(2'd0, 16'd7);
        host_wr(2'd1, 16'hC3E1);
        host_wr(2'd2, 16'h0005);
        host_wr(2'd0, 16'd20);
        host_wr(2'd1, 16'h1111);
        host_wr(2'd2, 16'h0006);
        wait_idle();
        repeat (40) @(negedge clk);
        check(ptr_rd == 6'd7, "R9 ptr ignored", ptr_rd, 7);
        check(gp_rd == 16'hC3E1, "R9 gp ignored", gp_rd, 16'hC3E1);
        check(ctl_rd == 3'b100 && !ee_cs, "R9 ctl ignored", {ctl_rd, ee_cs}, 4'b1000);
        check(mem[7] == 16'hC3E1 && mem[20] == pat_b(20), "R9 memory", mem[20], pat_b(20));
        check(wen_frames == 1, "R6 no second enable", wen_frames, 1);

        check(min_gap >= 2 * DIV, "R8 select gap", min_gap, 2 * DIV);
        check(di_glitch == 0, "R11 data stable in high", di_glitch, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule